// File: doc/BRIEF.md
# Byte Program Sequencer

This block sits on the host side of a byte-wide flash that must be written with a program-and-verify loop. A single start pulse hands it a start address and a byte count. It then fetches each byte through a request/acknowledge data port and drives every command write and verify read through a request/acknowledge bus port. It holds a program-voltage enable high for the whole run. When the run ends it reports success, or a program error together with the address of the byte that would not take.

For every byte it issues a setup command and then the address/data write. It waits a fixed number of clock cycles for the program pulse, writes the verify command, waits again and reads the byte back. A readback that does not match triggers another pulse. Each byte has its own pulse budget, which starts from zero at every new address. Once all bytes verify, or one byte runs out of pulses, the sequencer writes the read-mode command and drops the program-voltage enable. A counter reports how many pulses the whole run used.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `vpp_en`, `bus_req`, `dreq`, `done` and `error` are low, and `pulse_total` is zero.
- R2: A start with a nonzero count raises `vpp_en` before the first data request. `vpp_en` stays high whenever `bus_req` is high.
- R3: Each program attempt is a write of data 8'h40 followed by a write whose address is the current byte address and whose data is the fetched byte.
- R4: After the address/data write is acknowledged, exactly PROG_WAIT_CYC cycles pass with no bus request, and then a write of 8'h C0 follows. After that write is acknowledged, exactly VERIFY_WAIT_CYC idle cycles pass before a read (`bus_we` low) of the same address.
- R5: A readback different from the fetched byte starts a new attempt at R3. The pulse budget of each byte starts from zero. If a byte still mismatches after MAX_PULSES pulses, the run ends with `error` and `fail_addr` holds that byte's address.
- R6: A matching readback on a byte that is not the last one fetches the next byte through `dreq`/`dack`. The address then increments by one, wrapping modulo 2^ADDR_W.
- R7: Every run with a nonzero count ends with a write of 8'h00. In the cycle after that write is acknowledged, `vpp_en` and `busy` are low, and exactly one of `done` and `error` pulses high for one cycle.
- R8: `pulse_total` is cleared at start and, at the end of a run, equals the number of address/data writes issued during it.
- R9: A start with a count of zero gives a `done` pulse in the next cycle, with no bus or data request and `vpp_en` left low.
- R10: A start while `busy` is high is ignored. The run continues with its original address, count and data.
- R11: A bus or data request, once raised, stays raised with its address, data and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | ADDR_W | First byte address |
| byte_count | input | CNT_W | Number of bytes to program |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: run finished, all bytes verified |
| error | output | 1 | One-cycle pulse: a byte exhausted its pulse budget |
| fail_addr | output | ADDR_W | Address of the failing byte |
| pulse_total | output | TOTAL_W | Program pulses used in the current/last run |
| vpp_en | output | 1 | Program-voltage enable |
| dreq | output | 1 | Request for the next data byte |
| dack | input | 1 | Data byte presented on `ddata` |
| ddata | input | DATA_W | Data byte |
| bus_req | output | 1 | Flash bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Flash address |
| bus_wdata | output | DATA_W | Write data or command code |
| bus_ack | input | 1 | Access complete; read data valid on `bus_rdata` |
| bus_rdata | input | DATA_W | Read data |

## Verification
The bench models a flash in which each byte verifies only after a computed number of pulses. The sweep includes bytes that need exactly the full budget and bytes that need one pulse more. A budget compared off by one would either flag a good byte or retry a bad one once too often, and `pulse_total` and the error pulse expose both. It measures the idle gap before the verify command and before the readback to the exact cycle, so a timer that reloads one short or one long shows up. It also runs across the top of the address space to catch a broken wrap, sends a start in the middle of a run, and uses a zero count, which must neither touch the bus nor raise the program voltage.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH,
      ST_SETUP,
      ST_PROG,
      ST_WAITP,
      ST_VCMD,
      ST_WAITV,
      ST_VREAD,
      ST_RESTORE
   } seq_state_t;

   localparam logic [7:0] CMD_SETUP  = 8'h40;
   localparam logic [7:0] CMD_VERIFY = 8'hC0;
   localparam logic [7:0] CMD_READ   = 8'h00;

endpackage

// File: rtl/prog_wait_timer.sv
module prog_wait_timer #(
   parameter int PROG_WAIT_CYC   = 1250,
   parameter int VERIFY_WAIT_CYC = 750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic sel_verify,
   input  logic dec,
   output logic zero
);
   localparam int LONGEST = (PROG_WAIT_CYC > VERIFY_WAIT_CYC) ? PROG_WAIT_CYC : VERIFY_WAIT_CYC;
   localparam int TMR_W   = $clog2(LONGEST + 1);

   logic [TMR_W-1:0] tmr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tmr_q <= '0;
      else if (load)
         tmr_q <= sel_verify ? TMR_W'(VERIFY_WAIT_CYC - 1) : TMR_W'(PROG_WAIT_CYC - 1);
      else if (dec)
         tmr_q <= tmr_q - 1'b1;
   end

   assign zero = (tmr_q == '0);

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !zero);
endmodule

// File: rtl/prog_pulse_tracker.sv
module prog_pulse_tracker #(
   parameter int MAX_PULSES     = 25,
   parameter int TOTAL_W        = 16,
   parameter bit SATURATE_TOTAL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_run,
   input  logic               clr_byte,
   input  logic               pulse,
   output logic               limit,
   output logic [TOTAL_W-1:0] total
);
   localparam int PC_W = $clog2(MAX_PULSES + 1);

   logic [PC_W-1:0] pcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_byte || clr_run)
         pcnt_q <= '0;
      else if (pulse)
         pcnt_q <= pcnt_q + 1'b1;
   end

   assign limit = (pcnt_q == PC_W'(MAX_PULSES));

   generate
      if (SATURATE_TOTAL) begin : g_sat_total
         always_ff @(posedge clk) begin
            if (!rst_n || clr_run)
               total <= '0;
            else if (pulse && (total != '1))
               total <= total + 1'b1;
         end
      end else begin : g_wrap_total
         always_ff @(posedge clk) begin
            if (!rst_n || clr_run)
               total <= '0;
            else if (pulse)
               total <= total + 1'b1;
         end
      end
   endgenerate

   p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= PC_W'(MAX_PULSES));
   p_no_pulse_past_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (limit && !clr_byte && !clr_run) |-> !pulse);
endmodule

// File: rtl/prog_addr_walker.sv
module prog_addr_walker #(
   parameter int ADDR_W = 17,
   parameter int CNT_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr     <= '0;
         remain_q <= '0;
      end else if (load) begin
         addr     <= load_addr;
         remain_q <= load_cnt;
      end else if (advance) begin
         addr     <= addr + 1'b1;
         remain_q <= remain_q - 1'b1;
      end
   end

   assign last = (remain_q == CNT_W'(1));

   p_advance_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> (addr == $past(addr) + 1'b1));
   p_no_advance_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> !last);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import prog_seq_pkg::*;
#(
   parameter int ADDR_W          = 17,
   parameter int CNT_W           = 18,
   parameter int DATA_W          = 8,
   parameter int MAX_PULSES      = 25,
   parameter int PROG_WAIT_CYC   = 1250,
   parameter int VERIFY_WAIT_CYC = 750,
   parameter int TOTAL_W         = 16,
   parameter bit SATURATE_TOTAL  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  start_addr,
   input  logic [CNT_W-1:0]   byte_count,
   output logic               busy,
   output logic               done,
   output logic               error,
   output logic [ADDR_W-1:0]  fail_addr,
   output logic [TOTAL_W-1:0] pulse_total,
   output logic               vpp_en,
   output logic               dreq,
   input  logic               dack,
   input  logic [DATA_W-1:0]  ddata,
   output logic               bus_req,
   output logic               bus_we,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic               bus_ack,
   input  logic [DATA_W-1:0]  bus_rdata
);
   localparam logic [DATA_W-1:0] W_SETUP  = DATA_W'(CMD_SETUP);
   localparam logic [DATA_W-1:0] W_VERIFY = DATA_W'(CMD_VERIFY);
   localparam logic [DATA_W-1:0] W_READ   = DATA_W'(CMD_READ);

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must hold an 8-bit command code");
      end
      if (MAX_PULSES < 1) begin : g_bad_max_pulses
         $error("MAX_PULSES must be at least 1");
      end
      if ((PROG_WAIT_CYC < 1) || (VERIFY_WAIT_CYC < 1)) begin : g_bad_wait
         $error("wait times must be at least one cycle");
      end
      if (ADDR_W < 1 || CNT_W < 1 || TOTAL_W < 1) begin : g_bad_widths
         $error("widths must be positive");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic [DATA_W-1:0] data_q;
   logic              vpp_q, done_q, err_q, fail_pend_q;
   logic [ADDR_W-1:0] fail_q;

   logic walk_load, walk_adv, walk_last;
   logic clr_run, clr_byte, pulse, limit;
   logic t_load, t_sel, t_dec, t_zero;
   logic cap_data, vpp_on, vpp_off, done_set, err_set, fail_mark;
   logic [ADDR_W-1:0] cur_addr;

   prog_addr_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_walker (
      .clk(clk), .rst_n(rst_n), .load(walk_load), .load_addr(start_addr),
      .load_cnt(byte_count), .advance(walk_adv), .addr(cur_addr), .last(walk_last));

   prog_pulse_tracker #(.MAX_PULSES(MAX_PULSES), .TOTAL_W(TOTAL_W),
                        .SATURATE_TOTAL(SATURATE_TOTAL)) i_pulses (
      .clk(clk), .rst_n(rst_n), .clr_run(clr_run), .clr_byte(clr_byte),
      .pulse(pulse), .limit(limit), .total(pulse_total));

   prog_wait_timer #(.PROG_WAIT_CYC(PROG_WAIT_CYC),
                     .VERIFY_WAIT_CYC(VERIFY_WAIT_CYC)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .sel_verify(t_sel),
      .dec(t_dec), .zero(t_zero));

   // next-state and control strobes
   always_comb begin
      state_d   = state_q;
      walk_load = 1'b0;
      walk_adv  = 1'b0;
      clr_run   = 1'b0;
      clr_byte  = 1'b0;
      pulse     = 1'b0;
      t_load    = 1'b0;
      t_sel     = 1'b0;
      t_dec     = 1'b0;
      cap_data  = 1'b0;
      vpp_on    = 1'b0;
      vpp_off   = 1'b0;
      done_set  = 1'b0;
      err_set   = 1'b0;
      fail_mark = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               if (byte_count == '0) begin
                  done_set = 1'b1;
               end else begin
                  walk_load = 1'b1;
                  clr_run   = 1'b1;
                  vpp_on    = 1'b1;
                  state_d   = ST_FETCH;
               end
            end
         end
         ST_FETCH: begin
            if (dack) begin
               cap_data = 1'b1;
               clr_byte = 1'b1;
               state_d  = ST_SETUP;
            end
         end
         ST_SETUP: begin
            if (bus_ack) state_d = ST_PROG;
         end
         ST_PROG: begin
            if (bus_ack) begin
               pulse   = 1'b1;
               t_load  = 1'b1;
               state_d = ST_WAITP;
            end
         end
         ST_WAITP: begin
            if (t_zero) state_d = ST_VCMD;
            else        t_dec   = 1'b1;
         end
         ST_VCMD: begin
            if (bus_ack) begin
               t_load  = 1'b1;
               t_sel   = 1'b1;
               state_d = ST_WAITV;
            end
         end
         ST_WAITV: begin
            if (t_zero) state_d = ST_VREAD;
            else        t_dec   = 1'b1;
         end
         ST_VREAD: begin
            if (bus_ack) begin
               if (bus_rdata == data_q) begin
                  if (walk_last) begin
                     state_d = ST_RESTORE;
                  end else begin
                     walk_adv = 1'b1;
                     state_d  = ST_FETCH;
                  end
               end else if (limit) begin
                  fail_mark = 1'b1;
                  state_d   = ST_RESTORE;
               end else begin
                  state_d = ST_SETUP;
               end
            end
         end
         ST_RESTORE: begin
            if (bus_ack) begin
               vpp_off  = 1'b1;
               done_set = !fail_pend_q;
               err_set  = fail_pend_q;
               state_d  = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         data_q      <= '0;
         vpp_q       <= 1'b0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         fail_pend_q <= 1'b0;
         fail_q      <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= done_set;
         err_q   <= err_set;
         if (cap_data) data_q <= ddata;
         if (vpp_on)       vpp_q <= 1'b1;
         else if (vpp_off) vpp_q <= 1'b0;
         if (clr_run) fail_pend_q <= 1'b0;
         else if (fail_mark) begin
            fail_pend_q <= 1'b1;
            fail_q      <= cur_addr;
         end
      end
   end

   // bus and data port decode
   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b1;
      bus_wdata = W_READ;
      unique case (state_q)
         ST_SETUP:   begin bus_req = 1'b1; bus_wdata = W_SETUP;  end
         ST_PROG:    begin bus_req = 1'b1; bus_wdata = data_q;   end
         ST_VCMD:    begin bus_req = 1'b1; bus_wdata = W_VERIFY; end
         ST_VREAD:   begin bus_req = 1'b1; bus_we    = 1'b0;     end
         ST_RESTORE: begin bus_req = 1'b1; bus_wdata = W_READ;   end
         default:    ;
      endcase
   end

   assign bus_addr  = cur_addr;
   assign dreq      = (state_q == ST_FETCH);
   assign busy      = (state_q != ST_IDLE);
   assign vpp_en    = vpp_q;
   assign done      = done_q;
   assign error     = err_q;
   assign fail_addr = fail_q;

   p_req_under_vpp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req || dreq) |-> vpp_en);
   p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));
   p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && !dack) |=> dreq);
   p_vpp_drop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vpp_en) |-> ((done || error) && !busy));
   p_end_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |=> !(done || error));
endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
   localparam int AW = 4, CW = 4, DW = 8, MAXP = 5, PW = 6, VW = 3, TW = 8;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [CW-1:0] byte_count = '0;
   logic busy, done, error, vpp_en, dreq, bus_req, bus_we;
   logic [AW-1:0] fail_addr, bus_addr;
   logic [TW-1:0] pulse_total;
   logic dack = 1'b0, bus_ack = 1'b0;
   logic [DW-1:0] ddata = '0, bus_rdata = '0;
   logic [DW-1:0] bus_wdata;

   int checks = 0, failures = 0, cycles = 0;

   always #4 clk = ~clk;

   flash_prog_seq #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .MAX_PULSES(MAXP),
      .PROG_WAIT_CYC(PW), .VERIFY_WAIT_CYC(VW), .TOTAL_W(TW), .SATURATE_TOTAL(1'b1))
   i_flash_prog_seq (.*);

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: actual=%0d expected<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] byte_val(input int sa, input int i);
      return 8'((sa * 37 + i * 11 + 5) & 8'hFF);
   endfunction

   // need_mode 0: computed pattern, 1: every byte needs the full budget
   task automatic run_case(input int sa, input int cnt, input int lat,
                           input int fail_idx, input int need_mode, input bit intrude);
      int phase = 5, bi = 0, pulses = 0, total = 0, last_ack = 0, need = 0;
      int bwait = 0, dwait = 0;
      bit bpend = 0, dpend = 0, end_err = 0, finished = 0;
      logic [7:0] cur = '0, wlast = '0;
      @(negedge clk);
      start_addr = AW'(sa); byte_count = CW'(cnt); start = 1'b1;
      for (int c = 0; c < 20000 && !finished; c++) begin
         @(negedge clk);
         start = 1'b0; bus_ack = 1'b0; dack = 1'b0;
         if (intrude && c == 3) begin
            start = 1'b1; start_addr = AW'(sa + 7); byte_count = CW'(9);  // R10
         end
         need = (need_mode == 1) ? MAXP : (bi == fail_idx) ? MAXP + 1 : ((bi * 3 + sa + lat) % MAXP) + 1;
         if (phase == 6) begin
            chk(done == !end_err, "R7", "done pulse", done, !end_err);
            chk(error == end_err, "R5", "error pulse", error, end_err);
            chk(!vpp_en && !busy, "R7", "vpp/busy after end", {vpp_en, busy}, 0);
            chk(pulse_total == TW'(total), "R8", "pulse total", pulse_total, total);
            if (end_err)
               chk(fail_addr == AW'(sa + bi), "R5", "fail address", fail_addr, AW'(sa + bi));
            finished = 1;
         end else begin
            if (done || error) chk(0, "R7", "early end pulse", {done, error}, 0);
            if (dreq) begin
               if (!dpend) begin
                  chk(phase == 5, "R6", "unexpected data request", phase, 5);
                  chk(vpp_en, "R2", "vpp before fetch", vpp_en, 1);
                  dpend = 1; dwait = 0;
               end
               if (dwait >= lat) begin
                  cur = byte_val(sa, bi); ddata = cur; dack = 1'b1; dpend = 0;
                  pulses = 0; phase = 0;
               end else dwait++;
            end
            if (bus_req) begin
               if (!bpend) begin
                  chk(vpp_en, "R2", "vpp during request", vpp_en, 1);
                  case (phase)
                     0: chk(bus_we && bus_wdata == 8'h40, "R3", "setup write", bus_wdata, 8'h40);
                     1: begin
                        chk(bus_we && bus_wdata == cur, "R3", "program data", bus_wdata, cur);
                        chk(bus_addr == AW'(sa + bi), "R6", "program address", bus_addr, AW'(sa + bi));
                     end
                     2: begin
                        chk(bus_we && bus_wdata == 8'hC0, "R4", "verify command", bus_wdata, 8'hC0);
                        chk(c == last_ack + PW + 1, "R4", "program wait", c - last_ack - 1, PW);
                     end
                     3: begin
                        chk(!bus_we && bus_addr == AW'(sa + bi), "R4", "verify read address", bus_addr, AW'(sa + bi));
                        chk(c == last_ack + VW + 1, "R4", "verify wait", c - last_ack - 1, VW);
                     end
                     4: chk(bus_we && bus_wdata == 8'h00, "R7", "read-mode restore", bus_wdata, 8'h00);
                     default: chk(0, "R6", "bus request while fetch due", phase, 5);
                  endcase
                  bpend = 1; bwait = 0;
               end
               if (bwait >= lat) begin
                  bus_ack = 1'b1; bpend = 0;
                  case (phase)
                     0: phase = 1;
                     1: begin wlast = bus_wdata; pulses++; total++; last_ack = c; phase = 2; end
                     2: begin last_ack = c; phase = 3; end
                     3: begin
                        if (pulses >= need) begin
                           bus_rdata = wlast;
                           if (bi == cnt - 1) begin phase = 4; end_err = 0; end
                           else begin bi++; phase = 5; end
                        end else begin
                           bus_rdata = ~wlast;
                           if (pulses == MAXP) begin phase = 4; end_err = 1; end
                           else phase = 0;   // R5 retry
                        end
                     end
                     4: phase = 6;
                     default: ;
                  endcase
               end else bwait++;
            end else if (bpend) begin
               chk(0, "R11", "request dropped before ack", 0, 1);
               bpend = 0;
            end
         end
      end
      chk(finished, "R7", "run completed", finished, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !vpp_en && !bus_req && !dreq, "R1", "idle outputs", {busy, vpp_en, bus_req, dreq}, 0);
      chk(!done && !error && pulse_total == 0, "R1", "status after reset", {done, error, pulse_total}, 0);

      // R9: zero count
      start_addr = 4'd2; byte_count = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && !error, "R9", "zero-count done", {done, error}, 2'b10);
      chk(!vpp_en && !bus_req && !dreq && !busy, "R9", "no activity", {vpp_en, bus_req, dreq, busy}, 0);
      @(negedge clk);
      chk(!done && !bus_req && !dreq, "R9", "done single cycle", {done, bus_req, dreq}, 0);

      for (int s = 0; s < 6; s++)
         run_case((s * 5) % 16, s + 1, s % 3, -1, 0, s == 2);
      run_case(14, 4, 1, -1, 0, 0);   // R6 address wrap
      run_case(3, 2, 0, -1, 1, 0);    // R5 full budget still passes
      run_case(3, 4, 0, 2, 0, 0);     // R5 fails on third byte
      run_case(9, 3, 2, 0, 0, 0);     // R5 fails on first byte
      run_case(0, 15, 0, -1, 0, 0);   // R8 long run

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule